// File: doc/BRIEF.md
# Cache Line Refill Controller with Bus Error Abort

This block fetches a cache line from a burst-capable memory bus after a cache miss. A request taken while idle latches the miss address and the request kind. The block then runs one bus cycle. In burst mode the cycle reads the line beat by beat, starting at word 0 of the line. Each returned word goes into a line buffer. After the final beat arrives cleanly, the buffered line is presented to the cache data and tag arrays with a one-cycle write strobe and a per-word write mask.

A configuration input can shrink refills to a single word. In that mode the bus reads only the missed word, and the strobe writes only that word of the line. Uncached requests always use a single-word read and never write the cache. They only return the word with a completion pulse.

The bus error input counts only while a bus cycle is in progress. An error during a cycle ends it on the spot. Any remaining beats are dropped and nothing is installed. A one-cycle error pulse is raised on either the fetch-side or the data-side output, according to the kind of request that was in flight. An error that arrives at any other time, such as during write-buffer drains that this block never sees, has no effect.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset, bus_req, fill_we, done, err_ifetch and err_data are all 0.
- R2: A miss_req seen while idle starts the bus cycle: from the next cycle, bus_req is 1. For a cached request with cfg_single_word=0, bus_burst is 1 and bus_addr is the line base with word offset 0. After each accepted beat (bus_ack=1, bus_err=0), bus_addr advances by one word (DATA_W/8 bytes).
- R3: The word returned on beat k is stored as word k of the line. fill_line bits [k*DATA_W +: DATA_W] hold it.
- R4: One cycle after the last beat is accepted without error, fill_we and done are 1 for exactly one cycle. In that cycle, for a burst, fill_wmask is all ones, fill_index = miss_addr[LINE_OFS +: INDEX_W] and fill_tag = the top TAG_W bits of the miss address. done_word holds the missed word. LINE_OFS is log2(WORDS)+log2(DATA_W/8).
- R5: A bus_err sampled at a clock edge while bus_req is 1 ends the bus cycle: bus_req is 0 in the next cycle, and no further beats are requested.
- R6: A refill that saw a bus error never raises fill_we or done.
- R7: An aborted refill gives a one-cycle pulse in the cycle after the error. The pulse is on err_ifetch if miss_ifetch was 1 when the request was taken, and on err_data otherwise. Never both.
- R8: bus_err while bus_req is 0 is ignored: no error pulse, and no change to a request accepted in that same cycle.
- R9: With cfg_single_word=1, a cached request issues one read with bus_burst=0 at the word-aligned miss address. On success, fill_wmask is one-hot, with bit i set for miss word offset i.
- R10: An uncached request (miss_uncached=1) issues one read with bus_burst=0 at the word-aligned miss address. On success it pulses done with done_word, but fill_we stays 0.
- R11: After an abort the controller is idle in the cycle of the error pulse. A miss_req in that cycle starts a new bus cycle on the next cycle.
- R12: The miss address is latched on acceptance. Changes on miss_addr, and further miss_req pulses, while a bus cycle is active do not alter bus_addr, fill_index or fill_tag, and are not queued.
- R13: If bus_err and bus_ack arrive together on the last beat, the error wins: no install, and the error pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_single_word | input | 1 | 1: cached refills read one word only |
| miss_req | input | 1 | Miss request, taken when idle |
| miss_addr | input | ADDR_W | Byte address of the missed word |
| miss_ifetch | input | 1 | 1: instruction-fetch miss, 0: data miss |
| miss_uncached | input | 1 | 1: uncached single-word read, no install |
| bus_req | output | 1 | Bus cycle active |
| bus_burst | output | 1 | 1: multi-beat line read, 0: single read |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_ack | input | 1 | Read data valid for the current beat |
| bus_rdata | input | DATA_W | Read data |
| bus_err | input | 1 | Bus error, counted only during a bus cycle |
| fill_we | output | 1 | One-cycle cache array write strobe |
| fill_wmask | output | WORDS | Per-word write enable for the line |
| fill_index | output | INDEX_W | Cache set index |
| fill_tag | output | TAG_W | Tag to install |
| fill_line | output | WORDS*DATA_W | Line data, word k at bits k*DATA_W |
| done | output | 1 | Refill or uncached read finished cleanly |
| done_word | output | DATA_W | The missed word |
| err_ifetch | output | 1 | Fetch-side bus error pulse |
| err_data | output | 1 | Data-side bus error pulse |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is a bus error and the final data beat. The bench raises bus_err together with bus_ack on the last beat of a burst. It then requires no write strobe, no done pulse and the error pulse on the right side. The second pair is an error pulse and a new miss request. The bench holds miss_req high in the cycle the error pulse appears, and expects a fresh bus cycle at the new line address on the next cycle. A bus error raised in the same idle cycle as an accepted request must also leave that request untouched.

// File: rtl/refill_pkg.sv
package refill_pkg;
   typedef enum logic [0:0] {RF_IDLE = 1'b0, RF_BUS = 1'b1} rf_state_e;

   typedef struct packed {
      logic ifetch;
      logic uncached;
      logic single;
   } rf_kind_t;

   function automatic int unsigned rf_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/refill_seq.sv
module refill_seq
   import refill_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  miss_req,
   input  logic [ADDR_W-1:0]     miss_addr,
   input  rf_kind_t              miss_kind,
   input  logic                  bus_ack,
   input  logic                  bus_err,
   output logic                  bus_req,
   output logic                  bus_burst,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic                  beat_wr,
   output logic [rf_log2(WORDS)-1:0] beat_idx,
   output logic                  last_ok,
   output rf_kind_t              kind_q,
   output logic [ADDR_W-1:0]     addr_q,
   output logic                  err_ifetch,
   output logic                  err_data
);
   localparam int unsigned BYTE_OFS = rf_log2(DATA_W / 8);
   localparam int unsigned WOFS_W   = rf_log2(WORDS);
   localparam int unsigned LINE_OFS = WOFS_W + BYTE_OFS;
   localparam logic [WOFS_W-1:0] LAST_BEAT = WOFS_W'(WORDS - 1);

   rf_state_e          state_q;
   logic [WOFS_W-1:0]  beat_q;
   logic               in_bus, abort, is_last, accept;

   assign in_bus  = (state_q == RF_BUS);
   assign abort   = in_bus & bus_err;
   assign beat_wr = in_bus & bus_ack & ~bus_err;
   assign is_last = kind_q.single | (beat_q == LAST_BEAT);
   assign last_ok = beat_wr & is_last;
   assign accept  = (state_q == RF_IDLE) & miss_req;

   assign beat_idx  = kind_q.single ? addr_q[BYTE_OFS +: WOFS_W] : beat_q;
   assign bus_req   = in_bus;
   assign bus_burst = in_bus & ~kind_q.single;
   assign bus_addr  = {addr_q[ADDR_W-1:LINE_OFS], beat_idx, {BYTE_OFS{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RF_IDLE;
         beat_q  <= '0;
         addr_q  <= '0;
         kind_q  <= '0;
      end else begin
         unique case (state_q)
            RF_IDLE: begin
               if (accept) begin
                  state_q <= RF_BUS;
                  addr_q  <= miss_addr;
                  kind_q  <= miss_kind;
                  beat_q  <= '0;
               end
            end
            RF_BUS: begin
               if (abort) begin
                  state_q <= RF_IDLE;
               end else if (beat_wr) begin
                  if (is_last) state_q <= RF_IDLE;
                  else         beat_q  <= beat_q + 1'b1;
               end
            end
            default: state_q <= RF_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_ifetch <= 1'b0;
         err_data   <= 1'b0;
      end else begin
         err_ifetch <= abort &  kind_q.ifetch;
         err_data   <= abort & ~kind_q.ifetch;
      end
   end

   // R5
   bus_end_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err) |=> !bus_req);

   // R8
   idle_err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_req && bus_err) |=> !(err_ifetch || err_data));

   // R12
   line_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_err && !last_ok) |=>
         (bus_req && $stable(bus_addr[ADDR_W-1:LINE_OFS])));

   // R7
   err_side_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_ifetch, err_data}));
endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf
   import refill_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [rf_log2(WORDS)-1:0] wr_idx,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [rf_log2(WORDS)-1:0] sel_idx,
   output logic [WORDS*DATA_W-1:0]   line,
   output logic [DATA_W-1:0]         sel_word
);
   localparam int unsigned WOFS_W = rf_log2(WORDS);

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                            word_q[i] <= '0;
         else if (wr && wr_idx == WOFS_W'(i))   word_q[i] <= wdata;
      end
      assign line[i*DATA_W +: DATA_W] = word_q[i];
   end

   assign sel_word = word_q[sel_idx];
endmodule

// File: rtl/refill_fill.sv
module refill_fill
   import refill_pkg::*;
#(
   parameter int unsigned WORDS = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      last_ok,
   input  rf_kind_t                  kind,
   input  logic [rf_log2(WORDS)-1:0] word_ofs,
   output logic                      fill_we,
   output logic [WORDS-1:0]          fill_wmask,
   output logic                      done
);
   localparam int unsigned WOFS_W = rf_log2(WORDS);

   logic [WORDS-1:0] mask_d;

   for (genvar i = 0; i < WORDS; i++) begin : g_mask
      assign mask_d[i] = ~kind.single | (word_ofs == WOFS_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_we    <= 1'b0;
         done       <= 1'b0;
         fill_wmask <= '0;
      end else begin
         fill_we    <= last_ok & ~kind.uncached;
         done       <= last_ok;
         fill_wmask <= mask_d;
      end
   end
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
   import refill_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WORDS   = 4,
   parameter int unsigned INDEX_W = 8,
   localparam int unsigned BYTE_OFS = rf_log2(DATA_W / 8),
   localparam int unsigned WOFS_W   = rf_log2(WORDS),
   localparam int unsigned LINE_OFS = WOFS_W + BYTE_OFS,
   localparam int unsigned TAG_W    = ADDR_W - INDEX_W - LINE_OFS
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_single_word,
   input  logic                    miss_req,
   input  logic [ADDR_W-1:0]       miss_addr,
   input  logic                    miss_ifetch,
   input  logic                    miss_uncached,
   output logic                    bus_req,
   output logic                    bus_burst,
   output logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_ack,
   input  logic [DATA_W-1:0]       bus_rdata,
   input  logic                    bus_err,
   output logic                    fill_we,
   output logic [WORDS-1:0]        fill_wmask,
   output logic [INDEX_W-1:0]      fill_index,
   output logic [TAG_W-1:0]        fill_tag,
   output logic [WORDS*DATA_W-1:0] fill_line,
   output logic                    done,
   output logic [DATA_W-1:0]       done_word,
   output logic                    err_ifetch,
   output logic                    err_data
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (ADDR_W <= INDEX_W + LINE_OFS) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   rf_kind_t          req_kind, kind_q;
   logic              beat_wr, last_ok;
   logic [WOFS_W-1:0] beat_idx;
   logic [ADDR_W-1:0] addr_q;

   assign req_kind.ifetch   = miss_ifetch;
   assign req_kind.uncached = miss_uncached;
   assign req_kind.single   = miss_uncached | cfg_single_word;

   refill_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_req   (miss_req),
      .miss_addr  (miss_addr),
      .miss_kind  (req_kind),
      .bus_ack    (bus_ack),
      .bus_err    (bus_err),
      .bus_req    (bus_req),
      .bus_burst  (bus_burst),
      .bus_addr   (bus_addr),
      .beat_wr    (beat_wr),
      .beat_idx   (beat_idx),
      .last_ok    (last_ok),
      .kind_q     (kind_q),
      .addr_q     (addr_q),
      .err_ifetch (err_ifetch),
      .err_data   (err_data)
   );

   refill_linebuf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (beat_wr),
      .wr_idx   (beat_idx),
      .wdata    (bus_rdata),
      .sel_idx  (addr_q[BYTE_OFS +: WOFS_W]),
      .line     (fill_line),
      .sel_word (done_word)
   );

   refill_fill #(.WORDS(WORDS)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .last_ok    (last_ok),
      .kind       (kind_q),
      .word_ofs   (addr_q[BYTE_OFS +: WOFS_W]),
      .fill_we    (fill_we),
      .fill_wmask (fill_wmask),
      .done       (done)
   );

   assign fill_index = addr_q[LINE_OFS +: INDEX_W];
   assign fill_tag   = addr_q[ADDR_W-1 -: TAG_W];

   // R4
   fill_after_clean_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |-> $past(bus_req && bus_ack && !bus_err));

   // R6
   no_fill_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err) |=> (!fill_we && !done));

   // R7
   err_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ifetch || err_data) |-> $past(bus_req && bus_err));

   // R11
   restart_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_ifetch || err_data) && miss_req) |=> bus_req);

   // R10
   uncached_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fill_we) |-> $past(kind_q.uncached));
endmodule

// File: tb/sim_line_refill_ctrl.sv
`timescale 1ns/1ps
module sim_line_refill_ctrl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_single_word = 1'b0;
   logic         miss_req = 1'b0;
   logic [31:0]  miss_addr = '0;
   logic         miss_ifetch = 1'b0;
   logic         miss_uncached = 1'b0;
   logic         bus_req, bus_burst;
   logic [31:0]  bus_addr;
   logic         bus_ack = 1'b0;
   logic [31:0]  bus_rdata = '0;
   logic         bus_err = 1'b0;
   logic         fill_we, done, err_ifetch, err_data;
   logic [3:0]   fill_wmask;
   logic [7:0]   fill_index;
   logic [19:0]  fill_tag;
   logic [127:0] fill_line;
   logic [31:0]  done_word;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   line_refill_ctrl u0 (.*);

   function automatic logic [31:0] dat(input logic [31:0] a, input logic [7:0] k);
      return {a[15:0] ^ 16'hA5A5, k, 8'h3C};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic start(input logic [31:0] a, input bit ifx, input bit unc);
      miss_addr = a; miss_ifetch = ifx; miss_uncached = unc; miss_req = 1'b1;
      tick();
      miss_req = 1'b0;
   endtask

   task automatic feed_burst(input logic [31:0] a, input bit gap);
      for (int k = 0; k < 4; k++) begin
         chk(bus_addr == {a[31:4], k[1:0], 2'b00}, "R2", "beat address", bus_addr, {a[31:4], k[1:0], 2'b00});
         if (gap && k == 1) begin
            tick();
            chk(bus_addr == {a[31:4], 2'b01, 2'b00}, "R2", "address holds without ack", bus_addr, {a[31:4], 2'b01, 2'b00});
         end
         bus_ack = 1'b1; bus_rdata = dat(a, 8'(k));
         tick();
         bus_ack = 1'b0;
      end
   endtask

   task automatic check_fill(input logic [31:0] a);
      logic [127:0] exp_line;
      for (int k = 0; k < 4; k++) exp_line[k*32 +: 32] = dat(a, 8'(k));
      chk(fill_we && done, "R4", "fill_we/done after last beat", {fill_we, done}, 2'b11);
      chk(fill_wmask == 4'hF, "R4", "burst mask", fill_wmask, 4'hF);
      chk(fill_index == a[11:4], "R4", "index", fill_index, a[11:4]);
      chk(fill_tag == a[31:12], "R4", "tag", fill_tag, a[31:12]);
      chk(fill_line == exp_line, "R3", "line word order", fill_line, exp_line);
      chk(done_word == dat(a, {6'd0, a[3:2]}), "R4", "done_word", done_word, dat(a, {6'd0, a[3:2]}));
      chk(!bus_req, "R4", "bus idle after burst", bus_req, 0);
      tick();
      chk(!fill_we && !done, "R4", "strobe is one cycle", {fill_we, done}, 0);
   endtask

   task automatic t_reset();
      chk(!bus_req && !fill_we && !done && !err_ifetch && !err_data, "R1", "reset outputs",
          {bus_req, fill_we, done, err_ifetch, err_data}, 0);
   endtask

   task automatic t_burst(input logic [31:0] a, input bit ifx, input bit gap);
      start(a, ifx, 1'b0);
      chk(bus_req && bus_burst, "R2", "burst cycle started", {bus_req, bus_burst}, 2'b11);
      feed_burst(a, gap);
      check_fill(a);
   endtask

   task automatic t_abort(input logic [31:0] a, input bit ifx, input int k_err,
                          input logic [31:0] b);
      start(a, ifx, 1'b0);
      for (int k = 0; k < k_err; k++) begin
         bus_ack = 1'b1; bus_rdata = dat(a, 8'(k)); tick();
      end
      bus_ack = 1'b1; bus_err = 1'b1; bus_rdata = 32'hDEAD_BEEF;
      tick();
      bus_ack = 1'b0; bus_err = 1'b0;
      chk(!bus_req, "R5", "bus cycle ended by error", bus_req, 0);
      chk(!fill_we && !done, (k_err == 3) ? "R13" : "R6", "no install after error", {fill_we, done}, 0);
      chk(err_ifetch == ifx && err_data == !ifx, "R7", "error side", {err_ifetch, err_data}, {ifx, !ifx});
      miss_addr = b; miss_ifetch = 1'b0; miss_uncached = 1'b0; miss_req = 1'b1;
      tick();
      miss_req = 1'b0;
      chk(!err_ifetch && !err_data, "R7", "error pulse one cycle", {err_ifetch, err_data}, 0);
      chk(bus_req && bus_addr == {b[31:4], 4'h0}, "R11", "restart next cycle", bus_addr, {b[31:4], 4'h0});
      feed_burst(b, 1'b0);
      check_fill(b);
   endtask

   task automatic t_idle_err(input logic [31:0] a);
      bus_err = 1'b1; bus_ack = 1'b1;
      tick(); tick();
      chk(!err_ifetch && !err_data && !bus_req && !fill_we, "R8", "idle error ignored",
          {err_ifetch, err_data, bus_req, fill_we}, 0);
      miss_addr = a; miss_ifetch = 1'b1; miss_uncached = 1'b0; miss_req = 1'b1;
      tick();
      miss_req = 1'b0; bus_err = 1'b0; bus_ack = 1'b0;
      chk(bus_req && bus_addr == {a[31:4], 4'h0}, "R8", "request with idle error accepted", bus_addr, {a[31:4], 4'h0});
      chk(!err_ifetch && !err_data, "R8", "no pulse from idle error", {err_ifetch, err_data}, 0);
      feed_burst(a, 1'b0);
      check_fill(a);
   endtask

   task automatic t_single(input logic [31:0] a);
      cfg_single_word = 1'b1;
      start(a, 1'b0, 1'b0);
      chk(bus_req && !bus_burst, "R9", "single read", {bus_req, bus_burst}, 2'b10);
      chk(bus_addr == {a[31:2], 2'b00}, "R9", "single address", bus_addr, {a[31:2], 2'b00});
      bus_ack = 1'b1; bus_rdata = dat(a, 8'h77);
      tick();
      bus_ack = 1'b0;
      chk(fill_we && fill_wmask == (4'b1 << a[3:2]), "R9", "one-hot mask", fill_wmask, 4'b1 << a[3:2]);
      chk(fill_line[a[3:2]*32 +: 32] == dat(a, 8'h77), "R9", "word in place", fill_line[a[3:2]*32 +: 32], dat(a, 8'h77));
      chk(done_word == dat(a, 8'h77), "R9", "done_word", done_word, dat(a, 8'h77));
      tick();
      cfg_single_word = 1'b0;
   endtask

   task automatic t_uncached(input logic [31:0] a);
      start(a, 1'b0, 1'b1);
      chk(bus_req && !bus_burst && bus_addr == {a[31:2], 2'b00}, "R10", "uncached single read",
          bus_addr, {a[31:2], 2'b00});
      bus_ack = 1'b1; bus_rdata = dat(a, 8'h55);
      tick();
      bus_ack = 1'b0;
      chk(done && !fill_we, "R10", "done without install", {done, fill_we}, 2'b10);
      chk(done_word == dat(a, 8'h55), "R10", "uncached word", done_word, dat(a, 8'h55));
      miss_uncached = 1'b0;
      tick();
   endtask

   task automatic t_hold(input logic [31:0] a, input logic [31:0] other);
      start(a, 1'b1, 1'b0);
      bus_ack = 1'b1; bus_rdata = dat(a, 8'd0);
      miss_addr = other; miss_req = 1'b1;
      tick();
      miss_req = 1'b0; bus_ack = 1'b0;
      chk(bus_addr == {a[31:4], 4'h4}, "R12", "address kept on new request", bus_addr, {a[31:4], 4'h4});
      for (int k = 1; k < 4; k++) begin
         bus_ack = 1'b1; bus_rdata = dat(a, 8'(k)); tick();
      end
      bus_ack = 1'b0;
      chk(fill_we && fill_index == a[11:4] && fill_tag == a[31:12], "R12", "install at latched address",
          {fill_index, fill_tag}, {a[11:4], a[31:12]});
      tick();
      chk(!bus_req, "R12", "busy request not queued", bus_req, 0);
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_burst(32'h1234_5678, 1'b1, 1'b0);
      t_burst(32'h8000_0ABC, 1'b0, 1'b1);
      t_abort(32'h0000_4320, 1'b1, 1, 32'h0BAD_F00C);
      t_abort(32'h7654_3210, 1'b0, 0, 32'h1111_2224);
      t_abort(32'hCAFE_0018, 1'b0, 3, 32'h2222_3338);
      t_idle_err(32'h3333_4440);
      t_single(32'h4444_5558);
      t_uncached(32'h5555_6664);
      t_hold(32'h6666_7770, 32'h9999_AAA0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule